// File: doc/BRIEF.md
# Dual-Channel Qualified Pulse Controller

This block drives the two windings of a bistable, two-coil relay from two logic command lines. Each command line has to rise and then stay high for a qualification interval before it counts. A qualified command produces an active-low drive pulse on its own channel. That pulse has a hard upper length. The two channels exclude each other, so the two windings are never energised together. An enable line and a fault line (supply lockout or over-temperature, already digital) override everything. Either one stops any pulse at once and returns all control state to idle.

The pulse length depends on a static mode strap. In follow mode the drive is a copy of the command pulse, shifted later by the qualification interval. In fixed mode every qualified command gives a pulse of exactly the maximum length. All timing is counted in ticks of a prescaled timebase. The defaults assume 1 µs ticks from a 100 MHz clock, with 15 ms qualification and 150 ms maximum. The parameters cover qualification from 128 µs to 20 ms and maximum length from 1 ms to 350 ms. Command, enable and fault lines pass through two-flop synchronisers first.

Top module: `relay_pulse_ctrl`

## Requirements
- R1: After reset both drive outputs are high (inactive). A command line that is already high when reset ends does not start a pulse.
- R2: A command is recognised only on a low-to-high transition. After a pulse ends, a line that is still high produces no further pulse until it has been seen low.
- R3: A command line high for less than the qualification time (QUAL_TICKS ticks) produces no drive pulse.
- R4: In follow mode (fixed_mode = 0) the drive goes low about QUAL_TICKS ticks after the command rises. It stays low for as long as the command was high, within one tick.
- R5: In fixed mode (fixed_mode = 1) a qualified command gives a drive pulse of MAX_TICKS ticks, whatever the command width.
- R6: In either mode no drive pulse lasts longer than MAX_TICKS ticks, even if the command stays high.
- R7: If both command lines become qualified, neither drive fires. This applies when they rise together and when the second qualifies while the first is waiting. The two drives are never low together.
- R8: If the second line rises while the first is qualifying, but falls before it qualifies, the first command waits and then fires once the second line has fallen.
- R9: While one drive pulse runs, edges and levels on the other command line are ignored. A line that is still high when the pulse ends does not fire.
- R10: While en is low both drives are high. A running pulse ends within a few cycles, and commands given during that time produce no pulse.
- R11: While fault is high the block behaves as with en low. A qualification in progress is dropped and does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_a | input | 1 | Command line for channel A (asynchronous) |
| cmd_b | input | 1 | Command line for channel B (asynchronous) |
| en | input | 1 | Enable, high to allow drive (asynchronous) |
| fault | input | 1 | Lockout/over-temperature flag, high forces idle |
| fixed_mode | input | 1 | Static strap: 0 follow mode, 1 fixed-length mode |
| drv_a_n | output | 1 | Channel A coil drive, low = energise |
| drv_b_n | output | 1 | Channel B coil drive, low = energise |

## Verification
Two functions can act in the same cycle. One is the firing decision for a qualified channel. The other is the other channel's qualification finishing, or it starting on a fresh edge. The bench sets this up by staggering the two command lines a few ticks apart. In one case both stay high, so the pending first channel meets the second one's qualification and no pulse is allowed. In the other case the second line falls just before qualifying, and the first channel must fire at once when it falls. A scoreboard holds the expected pulses (channel, start cycle, width), and the monitor checks each observed pulse against them within one tick plus synchroniser latency. Cases that must produce nothing are judged by an empty queue and by the absence of any unexpected pulse.

// File: rtl/relay_pulse_pkg.sv
package relay_pulse_pkg;

    typedef enum logic {
        ST_ARMING = 1'b0,
        ST_FIRING = 1'b1
    } rpc_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rpc_tick.sv
module rpc_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int TW = $clog2(DIV);
            localparam logic [TW-1:0] LAST = TW'(DIV - 1);

            typedef struct packed {
                logic [TW-1:0] cnt;
                logic          tick;
            } tick_t;

            tick_t d, q;

            always_comb begin
                d      = q;
                d.tick = (q.cnt == LAST);
                d.cnt  = (q.cnt == LAST) ? '0 : q.cnt + TW'(1);
            end

            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end

            assign tick_o = q.tick;

            // R4 (timebase spacing keeps tick counts proportional to time)
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                q.tick |=> !q.tick);
        end
    endgenerate
endmodule

// File: rtl/rpc_core.sv
module rpc_core
    import relay_pulse_pkg::*;
#(
    parameter int QUAL_TICKS = 15000,
    parameter int MAX_TICKS  = 150000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              halt,
    input  logic              fixed_mode,
    input  logic [NUM_CH-1:0] cmd_s,
    output logic [NUM_CH-1:0] drive_o
);
    localparam int CW = $clog2(MAX_TICKS + 2);
    localparam logic [CW-1:0] QUAL_C = CW'(QUAL_TICKS);
    localparam logic [CW-1:0] MAX_C  = CW'(MAX_TICKS);

    typedef struct packed {
        rpc_state_e                   st;
        logic                         act;
        logic [NUM_CH-1:0]            arm;
        logic [NUM_CH-1:0]            run;
        logic [NUM_CH-1:0]            ok;
        logic [NUM_CH-1:0]            fell;
        logic [NUM_CH-1:0][CW-1:0]    hi;
        logic [CW-1:0]                on;
        logic [NUM_CH-1:0]            drive;
    } core_t;

    core_t d, q;
    logic  done;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (halt) begin
            d = '0;
        end else if (q.st == ST_ARMING) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (!q.run[c]) begin
                    if (!cmd_s[c]) begin
                        d.arm[c] = 1'b1;
                    end else if (q.arm[c]) begin
                        d.run[c]  = 1'b1;
                        d.arm[c]  = 1'b0;
                        d.ok[c]   = 1'b0;
                        d.fell[c] = 1'b0;
                        d.hi[c]   = '0;
                    end
                end else if (!q.ok[c]) begin
                    if (!cmd_s[c]) begin
                        d.run[c] = 1'b0;
                        d.arm[c] = 1'b1;
                    end else if (tick) begin
                        d.hi[c] = q.hi[c] + CW'(1);
                        if ((q.hi[c] + CW'(1)) >= QUAL_C) d.ok[c] = 1'b1;
                    end
                end else begin
                    if (!cmd_s[c]) d.fell[c] = 1'b1;
                    else if (tick && !q.fell[c] && q.hi[c] < MAX_C)
                        d.hi[c] = q.hi[c] + CW'(1);
                end
            end
            if (q.ok[0] && q.ok[1]) begin
                d.run = '0;
                d.ok  = '0;
                d.arm = '0;
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (q.ok[c] && !q.run[1-c]) begin
                        d.st       = ST_FIRING;
                        d.act      = 1'(c);
                        d.on       = '0;
                        d.drive[c] = 1'b1;
                        d.run[1-c] = 1'b0;
                        d.arm[1-c] = 1'b0;
                    end
                end
            end
        end else begin
            d.run[~q.act] = 1'b0;
            d.arm[~q.act] = 1'b0;
            if (!cmd_s[q.act]) d.fell[q.act] = 1'b1;
            else if (tick && !q.fell[q.act] && q.hi[q.act] < MAX_C)
                d.hi[q.act] = q.hi[q.act] + CW'(1);
            if (tick) d.on = q.on + CW'(1);
            done = (q.on >= MAX_C) ||
                   (!fixed_mode && q.fell[q.act] && q.on >= q.hi[q.act]);
            if (done) begin
                d.st    = ST_ARMING;
                d.drive = '0;
                d.run   = '0;
                d.ok    = '0;
                d.fell  = '0;
                d.arm   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign drive_o = q.drive;

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (drive_o == '0));

    // R6
    on_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FIRING) |-> (q.on <= MAX_C));

    // R3
    fire_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FIRING && $past(q.st) != ST_FIRING) |-> (q.hi[q.act] >= QUAL_C));

    // R2
    edge_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (q.run[0] && !$past(q.run[0])) |-> $past(q.arm[0]));

    // R5
    fixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FIRING && fixed_mode && q.on < MAX_C && !halt) |=> (q.st == ST_FIRING));
endmodule

// File: rtl/relay_pulse_ctrl.sv
module relay_pulse_ctrl
    import relay_pulse_pkg::*;
#(
    parameter int TICK_DIV   = 100,
    parameter int QUAL_TICKS = 15000,
    parameter int MAX_TICKS  = 150000
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_a,
    input  logic cmd_b,
    input  logic en,
    input  logic fault,
    input  logic fixed_mode,
    output logic drv_a_n,
    output logic drv_b_n
);
    logic [3:0]        raw, syn;
    logic              tick, halt;
    logic [NUM_CH-1:0] drive;

    assign raw  = {fault, en, cmd_b, cmd_a};
    assign halt = ~syn[2] | syn[3];

    rpc_sync #(.WIDTH(4), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw),
        .sync_o  (syn)
    );

    rpc_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    rpc_core #(.QUAL_TICKS(QUAL_TICKS), .MAX_TICKS(MAX_TICKS)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .halt       (halt),
        .fixed_mode (fixed_mode),
        .cmd_s      (syn[1:0]),
        .drive_o    (drive)
    );

    assign drv_a_n = ~drive[0];
    assign drv_b_n = ~drive[1];

    // R7
    never_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(!drv_a_n && !drv_b_n));
endmodule

// File: tb/relay_pulse_ctrl_tb.sv
module relay_pulse_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int QT  = 5;
    localparam int MT  = 20;
    localparam int QC  = QT * DIV;
    localparam int MC  = MT * DIV;
    localparam int TOL = DIV + 5;

    typedef struct {
        int    ch;
        int    t0;
        int    w;
        string tag;
    } exp_t;

    exp_t  sb[$];
    logic  clk = 1'b0, rst = 1'b1;
    logic  cmd_a = 1'b1, cmd_b = 1'b0, en = 1'b1, fault = 1'b0, fixed_mode = 1'b0;
    logic  drv_a_n, drv_b_n;
    int    cyc = 0, n_chk = 0, n_bad = 0;
    string cur_tag = "R1";
    bit    overlap = 1'b0;
    logic  pa = 1'b1, pb = 1'b1;
    int    st_a = 0, st_b = 0;

    relay_pulse_ctrl #(.TICK_DIV(DIV), .QUAL_TICKS(QT), .MAX_TICKS(MT)) u_dut (
        .clk(clk), .rst(rst), .cmd_a(cmd_a), .cmd_b(cmd_b), .en(en),
        .fault(fault), .fixed_mode(fixed_mode), .drv_a_n(drv_a_n), .drv_b_n(drv_b_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int absdiff(int x, int y);
        return (x > y) ? x - y : y - x;
    endfunction

    task automatic check(bit good, string tag, string what, int act, int expv);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_pulse(int ch, int t0, int w);
        exp_t it;
        if (sb.size() == 0) begin
            check(1'b0, cur_tag, $sformatf("unexpected pulse ch%0d width", ch), w, 0);
        end else begin
            it = sb.pop_front();
            check(ch == it.ch && absdiff(t0, it.t0) <= TOL, it.tag,
                  $sformatf("pulse start ch%0d(exp ch%0d)", ch, it.ch), t0, it.t0);
            check(absdiff(w, it.w) <= TOL, it.tag, "pulse width", w, it.w);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!drv_a_n && !drv_b_n) overlap = 1'b1;
            if (pa && !drv_a_n) st_a = cyc;
            if (!pa && drv_a_n) finish_pulse(0, st_a, cyc - st_a);
            if (pb && !drv_b_n) st_b = cyc;
            if (!pb && drv_b_n) finish_pulse(1, st_b, cyc - st_b);
        end
        pa = drv_a_n;
        pb = drv_b_n;
    end

    task automatic push(int ch, int t0, int w, string tag);
        exp_t it;
        it.ch = ch; it.t0 = t0; it.w = w; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(int n);
        wait_n(n);
        check(sb.size() == 0, cur_tag, "expected pulses still outstanding", sb.size(), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL %s watchdog expired: actual running expected done", cur_tag);
        summary();
        $finish;
    end

    initial begin
        int t;
        // R1: cmd_a held high across reset
        wait_n(10);
        rst = 1'b0;
        wait_n(120);
        check(drv_a_n == 1'b1, "R1", "drv_a_n after reset with stuck command", drv_a_n, 1);
        check(drv_b_n == 1'b1, "R1", "drv_b_n after reset", drv_b_n, 1);
        settle(1);
        cmd_a = 1'b0;
        wait_n(30);

        // R4: follow mode, channel A 40 cycles
        cur_tag = "R4"; t = cyc;
        push(0, t + QC, 40, "R4"); cmd_a = 1'b1; wait_n(40); cmd_a = 1'b0;
        settle(150);
        // R4: follow mode, channel B 60 cycles
        t = cyc;
        push(1, t + QC, 60, "R4"); cmd_b = 1'b1; wait_n(60); cmd_b = 1'b0;
        settle(150);

        // R3: short pulse discarded
        cur_tag = "R3";
        cmd_a = 1'b1; wait_n(8); cmd_a = 1'b0;
        settle(150);

        // R6: long command capped in follow mode
        cur_tag = "R6"; t = cyc;
        push(0, t + QC, MC, "R6"); cmd_a = 1'b1; wait_n(200); cmd_a = 1'b0;
        settle(100);

        // R2: stuck-high line fires once only
        cur_tag = "R2"; t = cyc;
        push(1, t + QC, MC, "R2"); cmd_b = 1'b1;
        settle(300);
        cmd_b = 1'b0;
        wait_n(50);

        // R7: simultaneous rise
        cur_tag = "R7";
        cmd_a = 1'b1; cmd_b = 1'b1; wait_n(40); cmd_a = 1'b0; cmd_b = 1'b0;
        settle(150);
        // R7: second qualifies while first waits
        cmd_a = 1'b1; wait_n(8); cmd_b = 1'b1; wait_n(60); cmd_a = 1'b0; cmd_b = 1'b0;
        settle(150);

        // R5: fixed mode
        fixed_mode = 1'b1; wait_n(10);
        cur_tag = "R5"; t = cyc;
        push(0, t + QC, MC, "R5"); cmd_a = 1'b1; wait_n(30); cmd_a = 1'b0;
        settle(150);

        // R8: pending qualification then execute
        cur_tag = "R8"; t = cyc;
        push(0, t + 24, MC, "R8");
        cmd_a = 1'b1; wait_n(8); cmd_b = 1'b1; wait_n(16); cmd_b = 1'b0; wait_n(6); cmd_a = 1'b0;
        settle(150);

        // R9: other line ignored during a pulse, still high at the end
        cur_tag = "R9"; t = cyc;
        push(0, t + QC, MC, "R9");
        cmd_a = 1'b1; wait_n(30); cmd_a = 1'b0; wait_n(10);
        cmd_b = 1'b1; wait_n(110);
        settle(60);
        cmd_b = 1'b0;
        settle(100);

        // R10: enable drop truncates pulse, commands ignored while low
        cur_tag = "R10"; t = cyc;
        push(0, t + QC, 30, "R10");
        cmd_a = 1'b1; wait_n(30); cmd_a = 1'b0; wait_n(20);
        en = 1'b0; wait_n(10);
        cmd_b = 1'b1; wait_n(35); cmd_b = 1'b0; wait_n(5);
        en = 1'b1;
        settle(150);

        // R11: fault during qualification drops it
        cur_tag = "R11";
        cmd_a = 1'b1; wait_n(10); fault = 1'b1; wait_n(20); fault = 1'b0; wait_n(30); cmd_a = 1'b0;
        settle(150);

        // R7: drives never overlapped across the run
        check(!overlap, "R7", "both drives low at once", overlap, 0);
        summary();
        $finish;
    end
endmodule